// File: doc/BRIEF.md
# Redirection-Table Interrupt Router

This block takes a bank of external interrupt lines and turns each one into a routed interrupt message. Every line owns a 64-bit redirection entry. The entry sets the vector, how the message is delivered, where it goes, and whether the line is edge or level sensitive. A mask bit in the entry silences the line. Software never addresses an entry directly. It writes an internal index into a select register, then reads or writes the selected 32-bit word through a data window.

Each line keeps a pending flag. For an edge entry, a rising input sets the flag, and the flag clears once the message for that line has been accepted. For a level entry, the flag follows the input. A pending line is only sent once it has been armed. A line becomes armed on a rising input, and every line is armed again whenever software writes any table entry. When several armed, pending and unmasked lines compete, the lowest-numbered line wins. One message at a time leaves on a valid/ready handshake, and its fields are frozen while it waits.

Top module: `irq_router`

## Requirements
- R1: After reset every table entry reads back as 0x0001_0000 (low word, only the mask bit 16 set) and 0 (high word), the identifier register reads zero, and no message is offered.
- R2: Bus offset 0x00 is the index-select register and reads back the stored index in bits 7:0. Bus offset 0x10 is the data window. Index 0x10+2n reaches the low word of entry n and 0x11+2n its high word, for n = 0..NUM_PINS-1.
- R3: Index 0 holds the identifier in bits 31:24, and the other bits read zero. Index 1 is read-only and reads 0x11 in bits 7:0 and NUM_PINS-1 in bits 23:16. Index 2 reads zero.
- R4: Indices 3..0x0F and those above the last entry read zero, and writes to them change nothing.
- R5: A message carries the entry's fields: vector in bits 7:0, delivery mode in 10:8, destination mode in bit 11, polarity in bit 13, trigger mode in bit 15 (1 = level) and destination in bits 63:56. It also carries the number of the line.
- R6: For an edge entry (bit 15 = 0), a rising input produces exactly one message. Holding the input high or letting it fall produces none. A later rising input produces another.
- R7: For a level entry, the pending flag follows the input. A line that fell low before it could be sent produces no message when it is later unmasked.
- R8: A line whose entry has bit 16 set sends nothing. An edge event seen while masked stays pending and is sent after an entry write clears the mask.
- R9: Lines that are ready at the same time are sent in ascending line order.
- R10: While msg_valid is high and msg_ready is low, msg_valid stays high and every message field stays unchanged. Only one message is outstanding.
- R11: A write to any table entry rescans all lines, so a level line that is still high is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on bus_rdata one cycle later |
| bus_addr | input | 8 | Register offset (0x00 index select, 0x10 data window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | NUM_PINS | Interrupt input lines, synchronous to clk |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Receiver accepts the offered message |
| msg_dest | output | 8 | Destination field |
| msg_dest_mode | output | 1 | Destination mode bit |
| msg_dlv_mode | output | 3 | Delivery mode field |
| msg_vector | output | 8 | Vector field |
| msg_polarity | output | 1 | Polarity bit, passed through |
| msg_trigger | output | 1 | Trigger mode, 1 = level |
| msg_pin | output | $clog2(NUM_PINS) | Number of the line that caused the message |

## Verification
The bench drives the inputs in several patterns:
- A single rising edge, then the input held high and then dropped. This separates edge detection from level sampling.
- A level line held high across an accept and across an unrelated entry write. This shows the difference between arming and pending.
- A pulse on a masked line, and a masked level line that falls before it is unmasked. These show that an edge event is remembered while a level state is not.
- Two lines raised in the same cycle with the receiver stalled. This exposes the line order and whether the offered message holds still.

Register tests cover the window halves, the fixed identifier and version words, and indices outside the table.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int WORD_W   = 32;
  localparam int ENTRY_W  = 2 * WORD_W;

  // Field positions inside one redirection entry
  localparam int VEC_LSB  = 0;
  localparam int DLV_LSB  = 8;
  localparam int DSTM_BIT = 11;
  localparam int POL_BIT  = 13;
  localparam int TRIG_BIT = 15;
  localparam int MASK_BIT = 16;
  localparam int DEST_LSB = 56;

  localparam logic [ENTRY_W-1:0] ENTRY_RST = ENTRY_W'(1) << MASK_BIT;
  localparam logic [7:0]         REV_CODE  = 8'h11;

  typedef struct packed {
    logic [7:0] dest;
    logic       dest_mode;
    logic [2:0] dlv_mode;
    logic [7:0] vector;
    logic       polarity;
    logic       trigger;
  } route_msg_t;

  function automatic route_msg_t entry_to_msg(input logic [ENTRY_W-1:0] e);
    route_msg_t m;
    m.dest      = e[DEST_LSB +: 8];
    m.dest_mode = e[DSTM_BIT];
    m.dlv_mode  = e[DLV_LSB +: 3];
    m.vector    = e[VEC_LSB +: 8];
    m.polarity  = e[POL_BIT];
    m.trigger   = e[TRIG_BIT];
    return m;
  endfunction

endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [WORD_W-1:0]     bus_wdata,
  output logic [WORD_W-1:0]     bus_rdata,
  output logic [IDX_W-1:0]      sel_idx,
  output logic [ENTRY_W-1:0]    entries [NUM_PINS],
  output logic                  entry_wr
);

  localparam int ENT_BASE = 16;
  localparam int ENT_LAST = ENT_BASE + 2 * NUM_PINS - 1;
  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_WIN = ADDR_W'(16);
  localparam logic [WORD_W-1:0] REV_WORD =
    {8'h00, 8'(NUM_PINS - 1), 8'h00, REV_CODE};

  logic [IDX_W-1:0]   sel_q;
  logic [7:0]         id_q;
  logic [IDX_W-1:0]   ent_off;
  logic [IDX_W-2:0]   ent_n;
  logic               in_tbl;
  logic               win_wr;
  logic [ENTRY_W-1:0] ent_sel;
  logic [WORD_W-1:0]  win_rd;

  assign sel_idx  = sel_q;
  assign ent_off  = sel_q - IDX_W'(ENT_BASE);
  assign ent_n    = ent_off[IDX_W-1:1];
  assign in_tbl   = (int'(sel_q) >= ENT_BASE) && (int'(sel_q) <= ENT_LAST);
  assign win_wr   = bus_wr && (bus_addr == A_WIN);
  assign entry_wr = win_wr && in_tbl;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (bus_wr && bus_addr == A_SEL) sel_q <= bus_wdata[IDX_W-1:0];
      if (win_wr && sel_q == '0)       id_q  <= bus_wdata[31:24];
    end
  end

  // Table storage: one 64-bit word per line, written a half at a time
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_PINS; i++) begin
      if (rst) begin
        entries[i] <= ENTRY_RST;
      end else if (entry_wr && ent_n == (IDX_W-1)'(i)) begin
        if (sel_q[0]) entries[i][ENTRY_W-1:WORD_W] <= bus_wdata;
        else          entries[i][WORD_W-1:0]       <= bus_wdata;
      end
    end
  end

  always_comb begin
    ent_sel = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (ent_n == (IDX_W-1)'(i)) ent_sel = entries[i];
  end

  always_comb begin
    case (sel_q)
      IDX_W'(0): win_rd = {id_q, 24'h0};
      IDX_W'(1): win_rd = REV_WORD;
      IDX_W'(2): win_rd = '0;
      default:   win_rd = !in_tbl ? '0 :
                          (sel_q[0] ? ent_sel[ENTRY_W-1:WORD_W] : ent_sel[WORD_W-1:0]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr == A_SEL)      bus_rdata <= {{(WORD_W-IDX_W){1'b0}}, sel_q};
      else if (bus_addr == A_WIN) bus_rdata <= win_rd;
      else                        bus_rdata <= '0;
    end
  end

endmodule

// File: rtl/irq_router_pend.sv
module irq_router_pend #(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [NUM_PINS-1:0] lvl_mode,
  input  logic                rearm,
  input  logic                ack,
  input  logic [PIN_W-1:0]    ack_pin,
  input  logic                ack_edge,
  output logic [NUM_PINS-1:0] pend,
  output logic [NUM_PINS-1:0] armed
);

  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] rise;
  logic [NUM_PINS-1:0] ack_hit;

  assign rise = irq_in & ~prev_q;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++)
      ack_hit[i] = ack && (ack_pin == PIN_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend   <= '0;
      armed  <= '0;
    end else begin
      prev_q <= irq_in;
      for (int i = 0; i < NUM_PINS; i++) begin
        if (lvl_mode[i]) pend[i] <= irq_in[i];
        else             pend[i] <= rise[i] | (pend[i] & ~(ack_hit[i] & ack_edge));
        armed[i] <= rise[i] | rearm | (armed[i] & ~ack_hit[i]);
      end
    end
  end

endmodule

// File: rtl/irq_router_issue.sv
module irq_router_issue
  import irq_router_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] cand,
  input  logic [ENTRY_W-1:0]  entries [NUM_PINS],
  input  logic                msg_ready,
  output logic                msg_valid,
  output route_msg_t          msg,
  output logic [PIN_W-1:0]    msg_pin
);

  logic               found;
  logic [PIN_W-1:0]   pick;
  logic [ENTRY_W-1:0] pick_ent;

  // Lowest-numbered candidate wins: scan downward so the last hit is the smallest
  always_comb begin
    found    = 1'b0;
    pick     = '0;
    pick_ent = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found    = 1'b1;
        pick     = PIN_W'(i);
        pick_ent = entries[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg       <= '0;
      msg_pin   <= '0;
    end else if (msg_valid) begin
      if (msg_ready) msg_valid <= 1'b0;
    end else if (found) begin
      msg_valid <= 1'b1;
      msg       <= entry_to_msg(pick_ent);
      msg_pin   <= pick;
    end
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = 8,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] irq_in,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_dest,
  output logic                msg_dest_mode,
  output logic [2:0]          msg_dlv_mode,
  output logic [7:0]          msg_vector,
  output logic                msg_polarity,
  output logic                msg_trigger,
  output logic [PIN_W-1:0]    msg_pin
);

  logic [ENTRY_W-1:0]  entries [NUM_PINS];
  logic [IDX_W-1:0]    sel_idx;
  logic                entry_wr;
  logic [NUM_PINS-1:0] mask_v, lvl_v, pend, armed, cand;
  route_msg_t          msg;

  irq_router_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sel_idx(sel_idx),
    .entries(entries), .entry_wr(entry_wr)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_fields
    assign mask_v[g] = entries[g][MASK_BIT];
    assign lvl_v[g]  = entries[g][TRIG_BIT];
  end

  irq_router_pend #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_pend (
    .clk(clk), .rst(rst), .irq_in(irq_in), .lvl_mode(lvl_v), .rearm(entry_wr),
    .ack(msg_valid && msg_ready), .ack_pin(msg_pin), .ack_edge(!msg.trigger),
    .pend(pend), .armed(armed)
  );

  assign cand = pend & armed & ~mask_v;

  irq_router_issue #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_issue (
    .clk(clk), .rst(rst), .cand(cand), .entries(entries), .msg_ready(msg_ready),
    .msg_valid(msg_valid), .msg(msg), .msg_pin(msg_pin)
  );

  assign msg_dest      = msg.dest;
  assign msg_dest_mode = msg.dest_mode;
  assign msg_dlv_mode  = msg.dlv_mode;
  assign msg_vector    = msg.vector;
  assign msg_polarity  = msg.polarity;
  assign msg_trigger   = msg.trigger;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = 8,
  parameter int PIN_W    = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [IDX_W-1:0]  sel_idx,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [7:0]        msg_vector,
  input logic [7:0]        msg_dest,
  input logic [PIN_W-1:0]  msg_pin
);

  AST_RST_IDLE: assert property (@(posedge clk) rst |=> !msg_valid); // R1

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid); // R10

  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> $stable(msg_vector) && $stable(msg_dest) && $stable(msg_pin)); // R10

  AST_PIN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> int'(msg_pin) < NUM_PINS); // R9

  AST_REV_WORD: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == ADDR_W'(16) && sel_idx == IDX_W'(1)
    |=> bus_rdata == {8'h00, 8'(NUM_PINS - 1), 8'h00, 8'h11}); // R3

  AST_GAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == ADDR_W'(16) && int'(sel_idx) >= 3 && int'(sel_idx) < 16
    |=> bus_rdata == 32'h0); // R4

endmodule

bind irq_router irq_router_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PIN_W(PIN_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .sel_idx(sel_idx), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_pin(msg_pin)
);

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;

  localparam int NP = 24;
  localparam int PW = $clog2(NP);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] irq_in = '0;
  logic          msg_valid, msg_ready = 1'b0;
  logic [7:0]    msg_dest, msg_vector;
  logic          msg_dest_mode, msg_polarity, msg_trigger;
  logic [2:0]    msg_dlv_mode;
  logic [PW-1:0] msg_pin;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  irq_router u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_dest_mode(msg_dest_mode), .msg_dlv_mode(msg_dlv_mode), .msg_vector(msg_vector),
    .msg_polarity(msg_polarity), .msg_trigger(msg_trigger), .msg_pin(msg_pin)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
    bus_write(8'h00, {24'h0, idx});
    bus_write(8'h10, d);
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
    bus_write(8'h00, {24'h0, idx});
    bus_read(8'h10, d);
  endtask

  // High word first so a pending line never sees a half-written entry
  task automatic set_entry(input int n, input logic [31:0] lo, input logic [31:0] hi);
    reg_write(8'(8'h11 + 2 * n), hi);
    reg_write(8'(8'h10 + 2 * n), lo);
  endtask

  task automatic wait_msg(output bit got);
    got = 1'b0;
    for (int k = 0; k < 20 && !got; k++) begin
      @(negedge clk);
      got = msg_valid;
    end
  endtask

  task automatic accept_msg();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic expect_none(input int cycles, input string req);
    int seen = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (msg_valid) seen++;
    end
    chk(req, seen, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 no message after reset", msg_valid, 0);
    reg_read(8'h00, v); chk("R1 id zero", v, 0);
    reg_read(8'h10, v); chk("R1 entry0 low masked", v, 32'h0001_0000);
    reg_read(8'h11, v); chk("R1 entry0 high zero", v, 0);
    reg_read(8'h3E, v); chk("R1 entry23 low masked", v, 32'h0001_0000);
  endtask

  task automatic t_window();
    logic [31:0] v;
    bus_write(8'h00, 32'h0000_003E);
    bus_read(8'h00, v);  chk("R2 index readback", v, 32'h3E);
    reg_write(8'h1B, 32'hAB00_0000);
    reg_write(8'h1A, 32'h0001_A831);
    reg_read(8'h1A, v);  chk("R2 entry5 low", v, 32'h0001_A831);
    reg_read(8'h1B, v);  chk("R2 entry5 high", v, 32'hAB00_0000);
    reg_read(8'h18, v);  chk("R2 entry4 untouched", v, 32'h0001_0000);
    reg_write(8'h00, 32'hFFFF_FFFF);
    reg_read(8'h00, v);  chk("R3 id bits 31:24", v, 32'hFF00_0000);
    reg_write(8'h01, 32'h0);
    reg_read(8'h01, v);  chk("R3 version word", v, 32'h0017_0011);
    reg_read(8'h02, v);  chk("R3 index2 zero", v, 0);
  endtask

  task automatic t_range();
    logic [31:0] v;
    reg_write(8'h40, 32'hDEAD_BEEF);
    reg_read(8'h40, v);  chk("R4 past table reads zero", v, 0);
    reg_read(8'h3F, v);  chk("R4 entry23 high unchanged", v, 0);
    reg_read(8'h3E, v);  chk("R4 entry23 low unchanged", v, 32'h0001_0000);
    reg_write(8'h05, 32'h1234_5678);
    reg_read(8'h05, v);  chk("R4 gap index reads zero", v, 0);
    reg_read(8'h10, v);  chk("R4 entry0 unchanged", v, 32'h0001_0000);
  endtask

  task automatic t_edge();
    bit got;
    set_entry(3, 32'h0000_2841, 32'h5A00_0000);
    @(negedge clk); irq_in[3] = 1'b1;
    wait_msg(got);
    chk("R6 edge gives message", got, 1);
    chk("R5 vector", msg_vector, 8'h41);
    chk("R5 destination", msg_dest, 8'h5A);
    chk("R5 dest mode", msg_dest_mode, 1);
    chk("R5 polarity", msg_polarity, 1);
    chk("R5 trigger edge", msg_trigger, 0);
    chk("R5 delivery mode", msg_dlv_mode, 0);
    chk("R5 pin", msg_pin, 3);
    accept_msg();
    expect_none(8, "R6 held high no repeat");
    irq_in[3] = 1'b0;
    expect_none(6, "R6 falling edge ignored");
    irq_in[3] = 1'b1;
    wait_msg(got);
    chk("R6 second rise gives message", got, 1);
    accept_msg();
    irq_in[3] = 1'b0;
    expect_none(4, "R6 single message per rise");
  endtask

  task automatic t_level();
    bit got;
    set_entry(4, 32'h0000_8799, 32'h1100_0000);
    @(negedge clk); irq_in[4] = 1'b1;
    wait_msg(got);
    chk("R7 level high gives message", got, 1);
    chk("R5 level trigger bit", msg_trigger, 1);
    chk("R5 level delivery mode", msg_dlv_mode, 7);
    chk("R5 level vector", msg_vector, 8'h99);
    accept_msg();
    expect_none(8, "R7 no repeat without rescan");
    reg_write(8'h19, 32'h1100_0000);
    wait_msg(got);
    chk("R11 entry write resends level line", got, 1);
    chk("R11 resent pin", msg_pin, 4);
    accept_msg();
    irq_in[4] = 1'b0;
    reg_write(8'h19, 32'h1100_0000);
    expect_none(6, "R7 low level not sent on rescan");
    reg_write(8'h18, 32'h0001_8799);
    irq_in[4] = 1'b1;
    expect_none(6, "R8 masked level line silent");
    irq_in[4] = 1'b0;
    @(negedge clk);
    reg_write(8'h18, 32'h0000_8799);
    expect_none(6, "R7 level dropped before unmask");
  endtask

  task automatic t_mask();
    bit got;
    set_entry(6, 32'h0001_0060, 32'h0);
    @(negedge clk); irq_in[6] = 1'b1;
    @(negedge clk); irq_in[6] = 1'b0;
    expect_none(6, "R8 masked edge line silent");
    reg_write(8'h1C, 32'h0000_0060);
    wait_msg(got);
    chk("R8 unmask sends held edge", got, 1);
    chk("R8 unmask pin", msg_pin, 6);
    chk("R8 unmask vector", msg_vector, 8'h60);
    accept_msg();
    expect_none(4, "R8 held edge sent once");
  endtask

  task automatic t_order();
    bit got;
    set_entry(9, 32'h0000_0029, 32'h0);
    set_entry(2, 32'h0000_0022, 32'h0);
    @(negedge clk); irq_in[2] = 1'b1; irq_in[9] = 1'b1;
    wait_msg(got);
    chk("R9 first message present", got, 1);
    chk("R9 lower line first", msg_pin, 2);
    repeat (4) @(negedge clk);
    chk("R10 valid held while stalled", msg_valid, 1);
    chk("R10 vector held while stalled", msg_vector, 8'h22);
    chk("R10 pin held while stalled", msg_pin, 2);
    accept_msg();
    wait_msg(got);
    chk("R9 second message present", got, 1);
    chk("R9 higher line second", msg_pin, 9);
    chk("R9 second vector", msg_vector, 8'h29);
    accept_msg();
    expect_none(6, "R10 nothing more outstanding");
    irq_in[2] = 1'b0; irq_in[9] = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_window();
    t_range();
    t_edge();
    t_level();
    t_mask();
    t_order();
    finish_run();
  end

endmodule